// File: doc/BRIEF.md
# SPI Register Access Slave

This block sits behind a four-wire serial port (clock, data in, data out, active-low select) and turns each select-framed burst into reads or writes of a 32-bit register space. The port runs in mode 0: the host changes MOSI while SCLK is low, and both sides sample on the rising edge. Every frame opens with one 32-bit command word, most significant bit first. That word holds the access direction, a word count for reads and a 21-bit word address. Payload words follow it, and the address steps by one word after each of them.

On the internal side the block is a plain synchronous register-bus master. A write puts out a one-cycle `bus_we` pulse with address and data. A read puts out a one-cycle `bus_re` pulse, and `bus_rdata` must be valid in the cycle after that pulse. Reads are fetched ahead of the serial shifter, so each returned word is on MISO as soon as its first bit is due.

Control is a five-state machine:
- **ST_IDLE**: select is high. Moves to ST_HEADER when select falls.
- **ST_HEADER**: collects the command word. When the word completes, it moves to ST_WRITE, to ST_READ, or (for a zero-count read) to ST_DRAIN.
- **ST_WRITE**: commits each received word. Moves to ST_DRAIN after the 64th word.
- **ST_READ**: loads fetched words into the shifter. Moves to ST_DRAIN once the last requested word has been shifted out.
- **ST_DRAIN**: ignores MOSI and shifts out zeros.

From any state, a high select returns the machine to ST_IDLE.

Top module: `spi_reg_slave`

## Requirements
- R1: Command bit 31 chooses the direction: 1 gives a write frame, which issues no `bus_re`, and 0 gives a read frame, which issues no `bus_we`. Bits 3..0 are ignored.
- R2: In a write frame, each complete 32-bit word after the command gives one `bus_we` pulse. `bus_wdata` carries the word, received MSB first. `bus_addr` starts at command bits 24..4 and rises by one per word.
- R3: A write frame commits at most 64 words. Any further words in the same frame give no `bus_we`.
- R4: In a read frame, command bits 30..25 give the count N. The block issues N `bus_re` pulses at consecutive addresses, starting at bits 24..4. It returns those N words on MISO, MSB first. The first returned bit is the one sampled on the 33rd rising SCLK edge.
- R5: A read whose count is 0 issues no `bus_re`, and MISO stays 0 for the whole frame.
- R6: After the last requested read word, MISO is 0 for any further clocks in the frame.
- R7: Raising CS_N partway through a word ends the frame and drops that partial word with no `bus_we`. The next frame starts again with a command word.
- R8: MISO is 0 while CS_N is high and during the 32 command bits.
- R9: After reset, `miso`, `bus_we`, `bus_re`, `bus_addr` and `bus_wdata` are all 0.
- R10: `bus_we` and `bus_re` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to host |
| bus_addr | output | 21 | Register word address |
| bus_wdata | output | 32 | Register write data |
| bus_we | output | 1 | Write strobe, one cycle |
| bus_re | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_re` |

## Verification
The assertions take for granted that SCLK, MOSI and CS_N are already synchronous to `clk`, with no synchronizer in the path. They also assume SCLK idles low when select changes, each SCLK phase lasts at least eight `clk` cycles, and select stays low for at least two cycles after the last rising edge of a complete word. The bench drives all serial pins on the falling edge of `clk`, holds each SCLK phase for exactly eight cycles, and waits half a bit time before raising select. Its register model answers `bus_re` with data one cycle later, which is the latency the read prefetch relies on.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 21;
    localparam int CNT_W    = 6;

    // command word field positions (the host decodes the same layout)
    localparam int DIR_BIT  = 31;
    localparam int CNT_HI   = 30;
    localparam int CNT_LO   = 25;
    localparam int ADDR_HI  = 24;
    localparam int ADDR_LO  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_WRITE,
        ST_READ,
        ST_DRAIN
    } frame_state_t;

endpackage

// File: rtl/spi_edge_rx.sv
module spi_edge_rx
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              fall,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word
);

    localparam int BIT_W = $clog2(WORD_W);

    logic              sclk_q;
    logic              rise;
    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] sr;

    assign rise = sclk & ~sclk_q & ~cs_n;
    assign fall = ~sclk & sclk_q & ~cs_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            bit_cnt   <= '0;
            sr        <= '0;
            word_done <= 1'b0;
            rx_word   <= '0;
        end else begin
            sclk_q    <= sclk;
            word_done <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                sr      <= {sr[WORD_W-2:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(WORD_W - 1)) begin
                    word_done <= 1'b1;
                    rx_word   <= {sr[WORD_W-2:0], mosi};
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fall,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    output logic              miso
);

    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (cs_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_data;
        end else if (fall) begin
            sr <= {sr[WORD_W-2:0], 1'b0};
        end
    end

    assign miso = sr[WORD_W-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_reg_pkg::*;
#(
    parameter int MAX_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fall,
    input  logic              word_done,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              tx_load,
    output logic [WORD_W-1:0] tx_data
);

    localparam int WCNT_W = $clog2(MAX_WORDS + 1);

    frame_state_t state, nxt;

    logic [ADDR_W-1:0] addr_ptr;
    logic [CNT_W-1:0]  words_left;
    logic [WCNT_W-1:0] wr_cnt;
    logic              load_pending;
    logic              re_q;
    logic [WORD_W-1:0] pf_data;

    logic              hdr_write;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [ADDR_W-1:0] hdr_addr;

    assign hdr_write = rx_word[DIR_BIT];
    assign hdr_cnt   = rx_word[CNT_HI:CNT_LO];
    assign hdr_addr  = rx_word[ADDR_HI:ADDR_LO];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_n) nxt = ST_HEADER;
            ST_HEADER: if (word_done) begin
                           if (hdr_write)          nxt = ST_WRITE;
                           else if (hdr_cnt == '0) nxt = ST_DRAIN;
                           else                    nxt = ST_READ;
                       end
            ST_WRITE:  if (word_done && wr_cnt == WCNT_W'(MAX_WORDS - 1)) nxt = ST_DRAIN;
            ST_READ:   if (word_done && words_left == '0) nxt = ST_DRAIN;
            ST_DRAIN:  nxt = ST_DRAIN;
            default:   nxt = ST_IDLE;
        endcase
        if (cs_n) nxt = ST_IDLE;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr     <= '0;
            bus_wdata    <= '0;
            bus_we       <= 1'b0;
            bus_re       <= 1'b0;
            tx_load      <= 1'b0;
            tx_data      <= '0;
            addr_ptr     <= '0;
            words_left   <= '0;
            wr_cnt       <= '0;
            load_pending <= 1'b0;
            re_q         <= 1'b0;
            pf_data      <= '0;
        end else begin
            bus_we  <= 1'b0;
            bus_re  <= 1'b0;
            tx_load <= 1'b0;
            re_q    <= bus_re;
            if (re_q) pf_data <= bus_rdata;
            if (cs_n) begin
                load_pending <= 1'b0;
                words_left   <= '0;
                wr_cnt       <= '0;
            end else begin
                unique case (state)
                    ST_HEADER: begin
                        if (word_done) begin
                            addr_ptr <= hdr_addr;
                            wr_cnt   <= '0;
                            if (!hdr_write && hdr_cnt != '0) begin
                                bus_re       <= 1'b1;
                                bus_addr     <= hdr_addr;
                                words_left   <= hdr_cnt;
                                load_pending <= 1'b1;
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (word_done) begin
                            bus_we    <= 1'b1;
                            bus_addr  <= addr_ptr;
                            bus_wdata <= rx_word;
                            addr_ptr  <= addr_ptr + 1'b1;
                            wr_cnt    <= wr_cnt + 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (fall && load_pending) begin
                            tx_load      <= 1'b1;
                            tx_data      <= pf_data;
                            words_left   <= words_left - 1'b1;
                            load_pending <= 1'b0;
                            if (words_left > CNT_W'(1)) begin
                                bus_re   <= 1'b1;
                                bus_addr <= addr_ptr + 1'b1;
                                addr_ptr <= addr_ptr + 1'b1;
                            end
                        end
                        if (word_done && words_left != '0) load_pending <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int MAX_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [WORD_W-1:0] bus_rdata
);

    logic              fall;
    logic              word_done;
    logic [WORD_W-1:0] rx_word;
    logic              tx_load;
    logic [WORD_W-1:0] tx_data;

    spi_edge_rx i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n),
        .fall      (fall),
        .word_done (word_done),
        .rx_word   (rx_word)
    );

    spi_frame_ctrl #(.MAX_WORDS(MAX_WORDS)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .fall      (fall),
        .word_done (word_done),
        .rx_word   (rx_word),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .tx_load   (tx_load),
        .tx_data   (tx_data)
    );

    spi_tx_shift i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .fall      (fall),
        .load      (tx_load),
        .load_data (tx_data),
        .miso      (miso)
    );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
    import spi_reg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              miso,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr
);

    logic              cs_q1, cs_q2;
    logic              we_seen;
    logic [ADDR_W-1:0] last_we_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q1        <= 1'b1;
            cs_q2        <= 1'b1;
            we_seen      <= 1'b0;
            last_we_addr <= '0;
        end else begin
            cs_q1 <= cs_n;
            cs_q2 <= cs_q1;
            if (bus_we) begin
                we_seen      <= 1'b1;
                last_we_addr <= bus_addr;
            end else if (cs_n && cs_q1 && cs_q2) begin
                we_seen <= 1'b0;
            end
        end
    end

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    a_r10_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we);

    a_r10_re_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re);

    a_r8_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cs_q1) |-> !miso);

    a_r7_no_we_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cs_q1 && cs_q2) |-> !bus_we);

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && we_seen) |-> (bus_addr == last_we_addr + 1'b1));

endmodule

bind spi_reg_slave spi_reg_slave_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .miso     (miso),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_addr (bus_addr)
);

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;

    localparam int HALF = 8;
    localparam int MAXW = 64;
    localparam int NVEC = 8;
    // {write(1), count(7), addr(21), seed(32)}
    localparam logic [60:0] VEC [0:NVEC-1] = '{
        {1'b1, 7'd4,  21'h000010, 32'h1111_0000},
        {1'b0, 7'd4,  21'h000010, 32'h0},
        {1'b0, 7'd3,  21'h000040, 32'h0},
        {1'b1, 7'd2,  21'h000020, 32'hDEAD_BE00},
        {1'b0, 7'd1,  21'h000021, 32'h0},
        {1'b0, 7'd0,  21'h000030, 32'h0},
        {1'b1, 7'd66, 21'h000080, 32'h8000_0001},
        {1'b0, 7'd63, 21'h000080, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        cs_n = 1'b1;
    logic        miso;
    logic [20:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata;

    always #2 clk = ~clk;

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .miso(miso), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] pat(input int i);
        return {8'hA5, i[7:0], ~i[7:0], 8'h3C};
    endfunction

    // register model, one-cycle read latency
    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            bus_rdata <= '0;
        end else begin
            if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
            if (bus_re) bus_rdata <= mem[bus_addr[7:0]];
        end
    end

    // bus event logs
    int          we_n = 0, re_n = 0;
    logic [20:0] we_addr [0:255];
    logic [31:0] we_data [0:255];
    always @(negedge clk) begin
        if (bus_we) begin
            we_addr[we_n & 255] = bus_addr;
            we_data[we_n & 255] = bus_wdata;
            we_n++;
        end
        if (bus_re) re_n++;
    end

    int          n_chk = 0, n_fail = 0;
    logic        done = 1'b0;
    logic [31:0] exp_mem  [0:255];
    logic [31:0] tx_words [0:79];
    logic [31:0] rx_words [0:79];
    logic        hdr_miso;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkhdr(input logic wr, input logic [5:0] cnt, input logic [20:0] a);
        return {wr, wr ? 6'd0 : cnt, a, 4'b0};
    endfunction

    task automatic xbit(input logic b, output logic o);
        mosi = b;
        repeat (HALF) @(negedge clk);
        o = miso;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic frame(input logic [31:0] hdr, input int nw, input int partial);
        logic o;
        @(negedge clk);
        cs_n = 1'b0;
        hdr_miso = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 31; b >= 0; b--) begin
            xbit(hdr[b], o);
            hdr_miso = hdr_miso | o;
        end
        for (int w = 0; w < nw; w++)
            for (int b = 31; b >= 0; b--) begin
                xbit(tx_words[w][b], o);
                rx_words[w][b] = o;
            end
        for (int p = 0; p < partial; p++) xbit(1'b1, o);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9: reset state
        chk(miso == 1'b0 && bus_we == 1'b0 && bus_re == 1'b0, "R9 strobes/miso", {29'd0, miso, bus_we, bus_re}, 32'd0);
        chk(bus_addr == '0 && bus_wdata == '0, "R9 addr/data", bus_wdata | 32'(bus_addr), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            logic        wr;
            int          cnt, bwe, bre, expn;
            logic [20:0] a;
            logic [31:0] seed;
            wr   = VEC[v][60];
            cnt  = int'(VEC[v][59:53]);
            a    = VEC[v][52:32];
            seed = VEC[v][31:0];
            bwe  = we_n;
            bre  = re_n;
            if (wr) begin
                for (int i = 0; i < cnt; i++) tx_words[i] = seed + 32'(i) * 32'h0001_0003;
                frame(mkhdr(1'b1, 6'd0, a), cnt, 0);
                expn = (cnt > MAXW) ? MAXW : cnt;
                chk(we_n - bwe == expn, "R3 write count", 32'(we_n - bwe), 32'(expn));
                chk(re_n == bre, "R1 no read in write frame", 32'(re_n - bre), 32'd0);
                for (int i = 0; i < expn; i++) begin
                    chk(we_addr[(bwe + i) & 255] == a + 21'(i), "R2 write addr", 32'(we_addr[(bwe + i) & 255]), 32'(a + 21'(i)));
                    chk(we_data[(bwe + i) & 255] == tx_words[i], "R2 write data", we_data[(bwe + i) & 255], tx_words[i]);
                    exp_mem[(int'(a) + i) & 255] = tx_words[i];
                end
            end else begin
                for (int i = 0; i <= cnt; i++) tx_words[i] = 32'hFFFF_FFFF;
                frame(mkhdr(1'b0, 6'(cnt), a), cnt + 1, 0);
                chk(re_n - bre == cnt, cnt == 0 ? "R5 no read strobe" : "R4 read strobes", 32'(re_n - bre), 32'(cnt));
                chk(we_n == bwe, "R1 no write in read frame", 32'(we_n - bwe), 32'd0);
                chk(hdr_miso == 1'b0, "R8 miso during command", {31'd0, hdr_miso}, 32'd0);
                for (int i = 0; i < cnt; i++)
                    chk(rx_words[i] == exp_mem[(int'(a) + i) & 255], "R4 read data", rx_words[i], exp_mem[(int'(a) + i) & 255]);
                chk(rx_words[cnt] == 32'd0, cnt == 0 ? "R5 zero-count miso" : "R6 trailing zeros", rx_words[cnt], 32'd0);
            end
        end

        // R7: abort mid-word, then a fresh frame
        begin
            int bwe;
            bwe = we_n;
            tx_words[0] = 32'h600D_F00D;
            frame(mkhdr(1'b1, 6'd0, 21'h60), 1, 20);
            chk(we_n - bwe == 1, "R7 partial word dropped", 32'(we_n - bwe), 32'd1);
            bwe = we_n;
            tx_words[0] = 32'h0BAD_CAFE;
            frame(mkhdr(1'b1, 6'd0, 21'h61), 1, 0);
            chk(we_n - bwe == 1, "R7 next frame count", 32'(we_n - bwe), 32'd1);
            chk(we_addr[bwe & 255] == 21'h61, "R7 next frame addr", 32'(we_addr[bwe & 255]), 32'h61);
            chk(we_data[bwe & 255] == 32'h0BAD_CAFE, "R7 next frame data", we_data[bwe & 255], 32'h0BAD_CAFE);
            @(negedge clk);
            chk(miso == 1'b0, "R8 miso deselected", {31'd0, miso}, 32'd0);
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R9: actual not finished expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule